// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner with Ambiguity Guard

This block finds word boundaries in a bit-serial stream that has no separate framing signal. The block receives one bit per clock on a bit-rate clock. Each 12-bit frame carries a high start bit, then ten data bits with the lowest-numbered bit first, then a low stop bit. The stop bit of one frame and the start bit of the next frame give a low-to-high transition once per frame, and this transition always falls at the same bit position. The aligner does not need a training or sync pattern. It watches live traffic and can join a link that is already carrying data.

For each of the twelve possible bit phases, the aligner counts how many consecutive frames showed a rising transition at that phase. A phase becomes a candidate once its count saturates. Constant data that holds one data bit low and the next data bit high creates a second steady candidate. In that case the aligner refuses to report lock until the data moves on and a single candidate remains. Once locked, the aligner emits one parallel word per frame with a one-cycle strobe. It drops lock after a run of frames in which the boundary transition is missing.

The state machine has four states. SEARCH is the reset state and has no candidate yet. AMBIG means two or more candidates exist. LOCKED means words are being delivered. SLEEP is powerdown. The transitions are:
- *single_found*: SEARCH or AMBIG goes to LOCKED when exactly one phase qualifies.
- *multi_found*: SEARCH or LOCKED goes to AMBIG when more than one phase qualifies.
- *all_lost*: AMBIG goes to SEARCH when no phase qualifies.
- *boundary_lost*: LOCKED goes to SEARCH after too many missing boundaries.
- *sleep_enter*: any state goes to SLEEP when both `pd_n` and `rx_en` are low.
- *wake*: SLEEP goes to SEARCH when `pd_n` rises.

Output high-impedance is modelled by `out_en_o`.

Top module: `frame_aligner`

## Requirements
- R1: After reset, `lock_n_o` is 1 and `word_stb_o` is 0, and `out_en_o` follows `rx_en` while not in powerdown.
- R2: A phase qualifies only after QUAL_FRAMES (default 8) consecutive frames with a 0-to-1 transition at that phase. A frame without the transition resets that phase's count. Lock is therefore never reported within the first QUAL_FRAMES-1 frames after a search starts.
- R3: On random live traffic with no sync pattern, the aligner locks, and its words match the transmitted words. This shows it locked at the true start-bit phase.
- R4: While more than one phase qualifies, `lock_n_o` stays 1 and no word strobe is produced. The test case is a constant word 0x3FE, which adds a transition between data bits 0 and 1.
- R5: Once the extra candidate breaks because the data changes, the aligner reaches lock.
- R6: The frame format is: start bit 1, data bits d0 to d9 in time order, stop bit 0. While locked, `word_o[i]` equals d_i of the frame just completed. `word_stb_o` is high for exactly one clock per frame, and only while locked.
- R7: With `rx_en` low and `pd_n` high, `out_en_o` is 0, but alignment is kept. Lock is still reported once `rx_en` returns high.
- R8: With `pd_n` low and `rx_en` high, the block is not in powerdown, and lock is kept.
- R9: With both `pd_n` and `rx_en` low, the block sleeps: `out_en_o` is 0, `lock_n_o` is 1, and all phase counts are cleared. After `pd_n` rises, `lock_n_o` stays 1 until alignment is found again.
- R10: While locked, MISS_FRAMES (default 4) consecutive frames without the boundary transition drop lock. Fewer consecutive misses are tolerated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data bit |
| rx_en | input | 1 | Receive enable; low disables the outputs |
| pd_n | input | 1 | Power control; low together with `rx_en` low enters powerdown |
| word_o | output | DATA_BITS | Recovered parallel word, bit i is the i-th data bit in time |
| word_stb_o | output | 1 | One-clock strobe per recovered word |
| lock_n_o | output | 1 | Active-low lock flag |
| out_en_o | output | 1 | Output enable; models the high-impedance control of the outputs |

## Verification
The bench checks recovered words against the transmitted words. A chosen phase that is off by even one bit therefore appears as a miscompare on the very first strobe after lock. A per-phase count that fails to clear, or that qualifies too early, appears within QUAL_FRAMES frames in one of two ways: lock asserts on the ambiguous constant pattern, or lock appears before the minimum number of frames after wake. A miss counter that is wrong by one shows up within MISS_FRAMES frames as lock kept or lock dropped on the wrong frame of a run of broken stop bits.

// File: rtl/frame_align_pkg.sv
`timescale 1ns/1ps
package frame_align_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_SEARCH = 2'd1,
        ST_AMBIG  = 2'd2,
        ST_LOCKED = 2'd3
    } align_state_e;

endpackage

// File: rtl/frame_phase_scan.sv
`timescale 1ns/1ps
// Tracks a per-phase run length of frames that showed a rising transition.
module frame_phase_scan #(
    parameter  int FRAME_BITS  = 12,
    parameter  int QUAL_FRAMES = 8,
    localparam int PW          = $clog2(FRAME_BITS),
    localparam int CW          = $clog2(QUAL_FRAMES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  din_i,
    output logic [PW-1:0]         phase_o,
    output logic                  edge_o,
    output logic [FRAME_BITS-1:0] qual_o
);

    logic          prev_q;
    logic [PW-1:0] ph_q;
    logic          edge_w;

    assign edge_w  = !prev_q && din_i;
    assign edge_o  = edge_w;
    assign phase_o = ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            ph_q   <= '0;
        end else begin
            prev_q <= din_i;
            if (clear_i || ph_q == PW'(FRAME_BITS - 1)) begin
                ph_q <= '0;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < FRAME_BITS; g++) begin : g_phase
        logic [CW-1:0] run_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (clear_i) begin
                run_q <= '0;
            end else if (ph_q == PW'(g)) begin
                if (!edge_w) begin
                    run_q <= '0;
                end else if (run_q != CW'(QUAL_FRAMES)) begin
                    run_q <= run_q + 1'b1;
                end
            end
        end

        assign qual_o[g] = (run_q == CW'(QUAL_FRAMES));

        // R2: run length saturates at the qualify threshold
        p_run_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            run_q <= CW'(QUAL_FRAMES));
    end

    // R2: phase index wraps once per frame
    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PW'(FRAME_BITS - 1) && !clear_i) |=> (ph_q == '0));

    // R9: clearing leaves no qualified phase behind
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (qual_o == '0));

endmodule

// File: rtl/frame_lock_fsm.sv
`timescale 1ns/1ps
// Decides lock from the qualified-phase set and watches the chosen boundary.
module frame_lock_fsm
    import frame_align_pkg::*;
#(
    parameter  int FRAME_BITS  = 12,
    parameter  int MISS_FRAMES = 4,
    localparam int PW          = $clog2(FRAME_BITS),
    localparam int MW          = $clog2(MISS_FRAMES + 1),
    localparam int NW          = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_en_i,
    input  logic                  pd_n_i,
    input  logic [PW-1:0]         phase_i,
    input  logic                  edge_i,
    input  logic [FRAME_BITS-1:0] qual_i,
    output logic                  clear_o,
    output align_state_e          state_o,
    output logic [PW-1:0]         sel_o
);

    align_state_e  state_q, state_d;
    logic [PW-1:0] sel_q;
    logic [MW-1:0] miss_q;
    logic [NW-1:0] n_qual;
    logic [PW-1:0] first_idx;
    logic          sleep_req;
    logic          at_sel;
    logic          miss_last;
    logic          drop_w;

    always_comb begin
        n_qual    = '0;
        first_idx = '0;
        for (int i = FRAME_BITS - 1; i >= 0; i--) begin
            if (qual_i[i]) begin
                n_qual    = n_qual + 1'b1;
                first_idx = PW'(i);
            end
        end
    end

    assign sleep_req = !pd_n_i && !rx_en_i;
    assign at_sel    = (phase_i == sel_q);
    assign miss_last = (miss_q == MW'(MISS_FRAMES - 1));
    assign drop_w    = (state_q == ST_LOCKED) && at_sel && !edge_i && miss_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (pd_n_i) state_d = ST_SEARCH;                  // wake
            end
            ST_SEARCH: begin
                if (n_qual == NW'(1))     state_d = ST_LOCKED;    // single_found
                else if (n_qual > NW'(1)) state_d = ST_AMBIG;     // multi_found
            end
            ST_AMBIG: begin
                if (n_qual == NW'(1))      state_d = ST_LOCKED;   // single_found
                else if (n_qual == NW'(0)) state_d = ST_SEARCH;   // all_lost
            end
            ST_LOCKED: begin
                if (drop_w)               state_d = ST_SEARCH;    // boundary_lost
                else if (n_qual > NW'(1)) state_d = ST_AMBIG;     // multi_found
            end
            default: state_d = ST_SEARCH;
        endcase
        if (sleep_req) state_d = ST_SLEEP;                        // sleep_enter
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    // Boundary selection and miss tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            miss_q <= '0;
        end else if (state_q != ST_LOCKED) begin
            miss_q <= '0;
            if (state_d == ST_LOCKED) sel_q <= first_idx;
        end else if (at_sel) begin
            if (edge_i || miss_last) miss_q <= '0;
            else                     miss_q <= miss_q + 1'b1;
        end
    end

    assign clear_o = (state_q == ST_SLEEP) || drop_w;
    assign state_o = state_q;
    assign sel_o   = sel_q;

    // R3: the chosen boundary does not move while locked
    p_sel_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && $past(state_q) == ST_LOCKED) |-> $stable(sel_q));

    // R4: lock is only entered from a single qualified phase
    p_lock_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && $past(state_q) != ST_LOCKED) |-> ($past(n_qual) == NW'(1)));

    // R10: miss count stays below the drop threshold while locked
    p_miss_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |-> (miss_q < MW'(MISS_FRAMES)));

    // R9: lock never follows a cycle that requested powerdown
    p_lock_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |-> $past(pd_n_i || rx_en_i));

endmodule

// File: rtl/frame_word_slicer.sv
`timescale 1ns/1ps
// Shifts the serial bits and releases a word at the stop-bit phase.
module frame_word_slicer #(
    parameter  int DATA_BITS  = 10,
    parameter  int FRAME_BITS = 12,
    localparam int PW         = $clog2(FRAME_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din_i,
    input  logic [PW-1:0]        phase_i,
    input  logic [PW-1:0]        sel_i,
    input  logic                 locked_i,
    output logic [DATA_BITS-1:0] word_o,
    output logic                 stb_o
);

    logic [DATA_BITS-1:0] sr_q;
    logic [DATA_BITS-1:0] ordered;
    logic [PW-1:0]        stop_phase;
    logic                 capture;

    // Oldest bit in the shifter is data bit 0
    for (genvar i = 0; i < DATA_BITS; i++) begin : g_order
        assign ordered[i] = sr_q[DATA_BITS-1-i];
    end

    assign stop_phase = (sel_i == '0) ? PW'(FRAME_BITS - 1) : sel_i - 1'b1;
    assign capture    = locked_i && (phase_i == stop_phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            word_o <= '0;
            stb_o  <= 1'b0;
        end else begin
            sr_q  <= {sr_q[DATA_BITS-2:0], din_i};
            stb_o <= capture;
            if (capture) word_o <= ordered;
        end
    end

    // R6: a strobe lasts exactly one clock
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);

endmodule

// File: rtl/frame_aligner.sv
`timescale 1ns/1ps
module frame_aligner
    import frame_align_pkg::*;
#(
    parameter  int DATA_BITS   = 10,
    parameter  int QUAL_FRAMES = 8,
    parameter  int MISS_FRAMES = 4,
    localparam int FRAME_BITS  = DATA_BITS + 2,
    localparam int PW          = $clog2(FRAME_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_din,
    input  logic                 rx_en,
    input  logic                 pd_n,
    output logic [DATA_BITS-1:0] word_o,
    output logic                 word_stb_o,
    output logic                 lock_n_o,
    output logic                 out_en_o
);

    logic [PW-1:0]         phase;
    logic                  edge_seen;
    logic [FRAME_BITS-1:0] qual;
    logic                  clear;
    align_state_e          state;
    logic [PW-1:0]         sel;
    logic                  locked;

    frame_phase_scan #(
        .FRAME_BITS (FRAME_BITS),
        .QUAL_FRAMES(QUAL_FRAMES)
    ) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear),
        .din_i  (ser_din),
        .phase_o(phase),
        .edge_o (edge_seen),
        .qual_o (qual)
    );

    frame_lock_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .MISS_FRAMES(MISS_FRAMES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en_i (rx_en),
        .pd_n_i  (pd_n),
        .phase_i (phase),
        .edge_i  (edge_seen),
        .qual_i  (qual),
        .clear_o (clear),
        .state_o (state),
        .sel_o   (sel)
    );

    frame_word_slicer #(
        .DATA_BITS (DATA_BITS),
        .FRAME_BITS(FRAME_BITS)
    ) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   (ser_din),
        .phase_i (phase),
        .sel_i   (sel),
        .locked_i(locked),
        .word_o  (word_o),
        .stb_o   (word_stb_o)
    );

    assign locked   = (state == ST_LOCKED);
    assign lock_n_o = !locked;
    assign out_en_o = rx_en && (state != ST_SLEEP);

    // R6: strobes only follow a locked cycle
    p_stb_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> $past(!lock_n_o));

endmodule

// File: tb/frame_aligner_bench.sv
`timescale 1ns/1ps
module frame_aligner_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_din = 1'b0;
    logic       rx_en = 1'b1;
    logic       pd_n = 1'b1;
    logic [9:0] word_o;
    logic       word_stb_o;
    logic       lock_n_o;
    logic       out_en_o;

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0, strobes = 0;
    logic [9:0]  exp_word = '0;
    logic [31:0] xs = 32'h1234_5677;

    // {transmitted word, expected recovered word}; neighbours are complements
    localparam logic [19:0] VECS [16] = '{
        {10'h2A5, 10'h2A5}, {10'h15A, 10'h15A}, {10'h3C1, 10'h3C1}, {10'h03E, 10'h03E},
        {10'h0F0, 10'h0F0}, {10'h30F, 10'h30F}, {10'h1B6, 10'h1B6}, {10'h249, 10'h249},
        {10'h377, 10'h377}, {10'h088, 10'h088}, {10'h0CC, 10'h0CC}, {10'h333, 10'h333},
        {10'h201, 10'h201}, {10'h1FE, 10'h1FE}, {10'h155, 10'h155}, {10'h2AA, 10'h2AA}
    };

    always #2.5 clk = ~clk;

    frame_aligner u_frame_aligner (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_din   (ser_din),
        .rx_en     (rx_en),
        .pd_n      (pd_n),
        .word_o    (word_o),
        .word_stb_o(word_stb_o),
        .lock_n_o  (lock_n_o),
        .out_en_o  (out_en_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_din = b;
    endtask

    task automatic send_frame(input logic [9:0] w, input logic stop_b, input logic [9:0] expw);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
        exp_word = expw;
        send_bit(stop_b);
    endtask

    task automatic rand_frame();
        logic [9:0] w;
        xs = xs ^ (xs << 13);
        xs = xs ^ (xs >> 17);
        xs = xs ^ (xs << 5);
        w = xs[9:0];
        send_frame(w, 1'b0, w);
    endtask

    task automatic wait_lock(input int maxf, input string tag);
        int k = 0;
        while (lock_n_o && k < maxf) begin
            rand_frame();
            k++;
        end
        chk(tag, int'(lock_n_o), 0);
    endtask

    task automatic sleep_and_wake();
        @(negedge clk);
        rx_en = 1'b0; pd_n = 1'b0; ser_din = 1'b0;
        repeat (3) send_bit(1'b0);
        chk("R9 out_en low in powerdown", int'(out_en_o), 0);
        chk("R9 lock_n high in powerdown", int'(lock_n_o), 1);
        repeat (20) send_bit(1'b0);
        @(negedge clk);
        pd_n = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        chk("R9 lock_n high right after wake", int'(lock_n_o), 1);
        chk("R9 out_en back after wake", int'(out_en_o), 1);
    endtask

    // Word monitor: every strobe must carry the frame just completed (R3, R6)
    always @(negedge clk) begin
        if (rst_n && word_stb_o) begin
            strobes++;
            mon_checks++;
            if (word_o !== exp_word) begin
                mon_fails++;
                $display("FAIL R3 R6 word actual=%h expected=%h", word_o, exp_word);
            end
        end
    end

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lock_n after reset", int'(lock_n_o), 1);
        chk("R1 strobe after reset", int'(word_stb_o), 0);
        chk("R1 out_en after reset", int'(out_en_o), 1);

        // Random live traffic, no sync pattern
        wait_lock(60, "R3 lock on random traffic");

        // Vector table walk: words out in order, one strobe per frame
        s0 = strobes;
        for (int i = 0; i < 16; i++) send_frame(VECS[i][19:10], 1'b0, VECS[i][9:0]);
        rand_frame();
        chk("R6 one strobe per frame", strobes - s0, 17);

        // Receive disable only
        rx_en = 1'b0;
        repeat (4) rand_frame();
        chk("R7 out_en low with rx_en low", int'(out_en_o), 0);
        rx_en = 1'b1;
        rand_frame();
        chk("R7 lock kept through rx_en low", int'(lock_n_o), 0);

        // Power pin low alone
        pd_n = 1'b0;
        repeat (4) rand_frame();
        chk("R8 no powerdown with rx_en high", int'(lock_n_o), 0);
        chk("R8 out_en stays high", int'(out_en_o), 1);
        pd_n = 1'b1;

        // Missing boundaries: three tolerated, four drop
        repeat (3) send_frame(10'h3FF, 1'b1, 10'h3FF);
        rand_frame();
        rand_frame();
        chk("R10 three misses tolerated", int'(lock_n_o), 0);
        repeat (4) send_frame(10'h3FF, 1'b1, 10'h3FF);
        rand_frame();
        chk("R10 four misses drop lock", int'(lock_n_o), 1);

        // Powerdown, then a repetitive pattern with an extra rising edge
        sleep_and_wake();
        s0 = strobes;
        for (int f = 0; f < 40; f++) begin
            send_frame(10'h3FE, 1'b0, 10'h3FE);
            chk("R4 lock held off on ambiguous pattern", int'(lock_n_o), 1);
        end
        chk("R4 no strobes while ambiguous", strobes - s0, 0);

        // Pattern changes: lock follows
        wait_lock(60, "R5 lock after pattern changes");
        repeat (3) rand_frame();
        chk("R5 lock stays after pattern changes", int'(lock_n_o), 0);

        // Qualification window after wake
        sleep_and_wake();
        repeat (7) rand_frame();
        chk("R2 no lock before qualify count", int'(lock_n_o), 1);
        repeat (5) rand_frame();
        chk("R2 lock once qualify count reached", int'(lock_n_o), 0);
        rand_frame();

        $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule